// File: doc/BRIEF.md
# Power-Down Wakeup Sequencer

This block decides when a small microcontroller core sleeps and when it wakes. Software writes a power-control register: one bit asks for idle (CPU clock stopped, oscillator running) and another asks for power-down (CPU clock and oscillator both stopped). While asleep, the block watches three external interrupt pins, a group of keypad inputs and the external reset pin. It chooses the source that ends the sleep and reports that source to the CPU.

Leaving power-down always passes through one shared hold counter. The oscillator enable comes back on at once, and the counter starts from zero. The CPU clock stays gated until the counter reaches all-ones. Only then does the block release the clock and pulse a wake flag with the source code. Interrupts set up for edge detection are sampled as levels while powered down, because a stopped clock cannot see an edge. In idle the edge setting still applies. A reset-pin wake also holds the clock until the pin has gone low again.

Top module: `pd_wake_seq`

## Requirements
- R1: After power-on reset (`por_n` low), the register reads 0x10, `cpu_clk_en` and `osc_en` are 1, and `in_powerdown` and `wake_valid` are 0.
- R2: System reset (`rst_n` low, `por_n` high) clears every register bit except bit 4, the power-on flag. Bit 4 keeps its value.
- R3: Writing bit 1 (power-down) puts the block into power-down two edges after the write is presented: `in_powerdown`=1, `cpu_clk_en`=0, `osc_en`=0. Register writes take effect only while the CPU clock is enabled.
- R4: Writing bits 1 and 0 both as 1 stores power-down=1 and idle=0, and the block enters power-down.
- R5: Writing bit 0 (idle) gates the CPU clock and keeps `osc_en`=1. An enabled wake condition returns to run on the next edge with `wake_valid`, and no hold count is run. In idle, an interrupt whose `ext_int_edge` bit is 1 needs a transition into its active level.
- R6: External interrupt n ends a sleep only when `ext_int_en[n]` is 1. Its active level is high when `ext_int_hi[n]`=1 and low otherwise. In power-down the level alone wakes, whatever `ext_int_edge[n]` says.
- R7: The keypad group ends a sleep when `kbd_ie`=1, `kbd_mask` is nonzero and `(kbd_pin ^ kbd_pattern) & kbd_mask` is zero.
- R8: A rising edge on `ext_rst_pin` ends a sleep. The CPU clock is not released until that pin is low and the hold count is done. Release then comes on the edge after the pin is seen low.
- R9: After a power-down wake condition, `osc_en` rises after the next edge. `cpu_clk_en` rises exactly 2^CNT_W edges later, unless R8 extends the wait.
- R10: `wake_src` is 0, 1 or 2 for an external interrupt, 3 for the keypad and 4 for reset. When sources coincide, priority is reset, then interrupt 0, 1, 2, then keypad. `wake_valid` is a one-cycle pulse on the cycle the clock is released.
- R11: Release clears register bits 1:0. A source that stays asserted after release does not start another sleep or hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-running block clock |
| por_n | input | 1 | Synchronous power-on reset, active low |
| rst_n | input | 1 | Synchronous system reset, active low |
| reg_we | input | 1 | Power-control register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data |
| ext_int_pin | input | 3 | External interrupt pins |
| ext_int_en | input | 3 | Per-interrupt enable |
| ext_int_hi | input | 3 | 1 = active high/rising, 0 = active low/falling |
| ext_int_edge | input | 3 | 1 = edge-configured, 0 = level-configured |
| kbd_pin | input | 8 | Keypad inputs |
| kbd_mask | input | 8 | Keypad bits taking part in the compare |
| kbd_pattern | input | 8 | Keypad compare pattern |
| kbd_ie | input | 1 | Keypad interrupt enable |
| ext_rst_pin | input | 1 | External reset pin, active high |
| osc_en | output | 1 | Oscillator enable |
| cpu_clk_en | output | 1 | CPU clock gate enable |
| in_powerdown | output | 1 | Block is in power-down |
| wake_valid | output | 1 | One-cycle pulse at clock release |
| wake_src | output | 3 | Code of the source that ended the sleep |

## Verification
Inputs are driven on falling edges and outputs are sampled on falling edges. Each check therefore sees the state after a known count of rising edges. A register write shows on readback after one edge and takes the block to power-down after two. A power-down wake shows on `osc_en` after one edge, and on `cpu_clk_en`, `wake_valid` and `wake_src` exactly 2^CNT_W edges after that. For a held reset pin, release comes one edge after the pin drop. The bench computes that edge and checks one cycle before it (still gated) and at it (released). An idle wake is checked one edge after the stimulus.

// File: rtl/pdw_pkg.sv
// Shared types and constants for the power-down wakeup sequencer.
// Assumes three external interrupt channels; source codes depend on that count.
package pdw_pkg;
    localparam int NUM_EXT = 3;
    localparam int SRC_W   = 3;
    localparam logic [SRC_W-1:0] SRC_KBD = SRC_W'(NUM_EXT);
    localparam logic [SRC_W-1:0] SRC_RST = SRC_W'(NUM_EXT + 1);
    localparam logic [7:0] CTRL_POR_VAL  = 8'h10;
    localparam logic [7:0] CTRL_KEEP_MSK = 8'h10;

    typedef enum logic [2:0] {
        ST_RUN,
        ST_IDLE,
        ST_PDOWN,
        ST_STAB,
        ST_RHOLD
    } pdw_state_e;
endpackage

// File: rtl/pdw_ctrl_reg.sv
// Power-control register. Bit 0 requests idle, bit 1 requests power-down,
// bit 4 is the power-on flag; all other bits are plain read/write storage.
// Assumes the sequencer raises clr_req only while writes are blocked.
module pdw_ctrl_reg
    import pdw_pkg::*;
(
    input  logic       clk,
    input  logic       por_n,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [7:0] wr_data,
    input  logic       clr_req,
    output logic [7:0] rd_data,
    output logic       pd_req,
    output logic       idle_req
);
    logic [7:0] ctrl_q;

    // Holds register state: power-on value, system-reset mask, auto-clear, write.
    always_ff @(posedge clk) begin
        if (!por_n) begin
            ctrl_q <= CTRL_POR_VAL;
        end else if (!rst_n) begin
            ctrl_q <= ctrl_q & CTRL_KEEP_MSK;
        end else if (clr_req) begin
            ctrl_q[1:0] <= 2'b00;
        end else if (wr_en) begin
            ctrl_q <= {wr_data[7:2], wr_data[1], wr_data[0] & ~wr_data[1]};
        end
    end

    assign rd_data  = ctrl_q;
    assign pd_req   = ctrl_q[1];
    assign idle_req = ctrl_q[0];

    assert_pd_wins_R4: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
        (wr_en && wr_data[1:0] == 2'b11 && !clr_req) |=> (pd_req && !idle_req));

    assert_pof_kept_R2: assert property (@(posedge clk) disable iff (!por_n)
        (!rst_n) |=> (rd_data[4] == $past(rd_data[4])));
endmodule

// File: rtl/pdw_wake_detect.sv
// Wake-source detector. Evaluates each interrupt channel, the keypad compare
// and the reset-pin rising edge, then picks one source by fixed priority.
// Assumes force_level is high only while the block is powered down.
module pdw_wake_detect
    import pdw_pkg::*;
#(
    parameter int KBD_W = 8
) (
    input  logic               clk,
    input  logic               rst_all_n,
    input  logic               force_level,
    input  logic [NUM_EXT-1:0] ext_pin,
    input  logic [NUM_EXT-1:0] ext_en,
    input  logic [NUM_EXT-1:0] ext_hi,
    input  logic [NUM_EXT-1:0] ext_edge,
    input  logic [KBD_W-1:0]   kbd_pin,
    input  logic [KBD_W-1:0]   kbd_mask,
    input  logic [KBD_W-1:0]   kbd_pattern,
    input  logic               kbd_ie,
    input  logic               rst_pin,
    output logic               hit_any,
    output logic [SRC_W-1:0]   hit_src
);
    localparam int NSRC = NUM_EXT + 2;

    logic [NUM_EXT-1:0] act_now;
    logic [NUM_EXT-1:0] act_prev;
    logic [NUM_EXT-1:0] ext_hit;
    logic               rst_prev;
    logic               kbd_hit;
    logic               rst_hit;
    logic [NSRC-1:0]    hit_vec;

    assign act_now = ~(ext_pin ^ ext_hi);

    // Remembers last-cycle activity for edge detection on every input.
    always_ff @(posedge clk) begin
        if (!rst_all_n) begin
            act_prev <= '0;
            rst_prev <= 1'b0;
        end else begin
            act_prev <= act_now;
            rst_prev <= rst_pin;
        end
    end

    generate
        for (genvar i = 0; i < NUM_EXT; i++) begin : g_ext
            // Level sense when forced or level-configured; otherwise needs a transition.
            assign ext_hit[i] = ext_en[i] & act_now[i]
                              & (force_level | ~ext_edge[i] | ~act_prev[i]);

            assert_edge_needs_change_R5: assert property (@(posedge clk) disable iff (!rst_all_n)
                (!force_level && ext_edge[i] && act_now[i] && act_prev[i]) |-> !ext_hit[i]);
        end
    endgenerate

    assign kbd_hit = kbd_ie & (|kbd_mask) & ~(|((kbd_pin ^ kbd_pattern) & kbd_mask));
    assign rst_hit = rst_pin & ~rst_prev;
    assign hit_vec = {rst_hit, kbd_hit, ext_hit};
    assign hit_any = |hit_vec;

    // Fixed-priority encoder: reset, then interrupt 0 upward, then keypad.
    always_comb begin
        hit_src = SRC_KBD;
        for (int i = NUM_EXT - 1; i >= 0; i--) begin
            if (ext_hit[i]) hit_src = SRC_W'(i);
        end
        if (rst_hit) hit_src = SRC_RST;
    end

    assert_kbd_gated_R7: assert property (@(posedge clk) disable iff (!rst_all_n)
        (hit_any && hit_src == SRC_KBD) |-> (kbd_ie && kbd_mask != '0));
endmodule

// File: rtl/pdw_seq.sv
// Sleep/wake state machine with the shared stabilization counter.
// Assumes hit_any/hit_src come from the detector of the same clock domain.
module pdw_seq
    import pdw_pkg::*;
#(
    parameter int CNT_W = 10
) (
    input  logic             clk,
    input  logic             rst_all_n,
    input  logic             pd_req,
    input  logic             idle_req,
    input  logic             hit_any,
    input  logic [SRC_W-1:0] hit_src,
    input  logic             rst_pin,
    output logic             osc_en,
    output logic             cpu_clk_en,
    output logic             in_pd,
    output logic             clr_req,
    output logic             wake_valid,
    output logic [SRC_W-1:0] wake_src
);
    pdw_state_e       st_q, st_nx;
    logic [CNT_W-1:0] cnt_q;
    logic             cnt_full;
    logic [SRC_W-1:0] src_q;
    logic             valid_q;
    logic             release_now;

    assign cnt_full = &cnt_q;

    // Chooses the next state and flags the cycle in which the clock is released.
    always_comb begin
        st_nx       = st_q;
        release_now = 1'b0;
        case (st_q)
            ST_RUN: begin
                if (pd_req)        st_nx = ST_PDOWN;
                else if (idle_req) st_nx = ST_IDLE;
            end
            ST_IDLE: begin
                if (hit_any) begin
                    if (hit_src == SRC_RST) begin
                        st_nx = ST_RHOLD;
                    end else begin
                        st_nx       = ST_RUN;
                        release_now = 1'b1;
                    end
                end
            end
            ST_PDOWN: begin
                if (hit_any) st_nx = ST_STAB;
            end
            ST_STAB: begin
                if (cnt_full) begin
                    if (src_q == SRC_RST && rst_pin) begin
                        st_nx = ST_RHOLD;
                    end else begin
                        st_nx       = ST_RUN;
                        release_now = 1'b1;
                    end
                end
            end
            ST_RHOLD: begin
                if (!rst_pin) begin
                    st_nx       = ST_RUN;
                    release_now = 1'b1;
                end
            end
            default: st_nx = ST_RUN;
        endcase
    end

    // Advances the state register.
    always_ff @(posedge clk) begin
        if (!rst_all_n) st_q <= ST_RUN;
        else            st_q <= st_nx;
    end

    // Clears the hold counter in power-down and counts up to all-ones while stabilizing.
    always_ff @(posedge clk) begin
        if (!rst_all_n)                      cnt_q <= '0;
        else if (st_q == ST_PDOWN)           cnt_q <= '0;
        else if (st_q == ST_STAB && !cnt_full) cnt_q <= cnt_q + 1'b1;
    end

    // Latches the winning source when a sleep ends.
    always_ff @(posedge clk) begin
        if (!rst_all_n) begin
            src_q <= '0;
        end else if ((st_q == ST_PDOWN || st_q == ST_IDLE) && hit_any) begin
            src_q <= hit_src;
        end
    end

    // Produces the one-cycle wake pulse aligned with the clock release.
    always_ff @(posedge clk) begin
        if (!rst_all_n) valid_q <= 1'b0;
        else            valid_q <= release_now;
    end

    assign cpu_clk_en = (st_q == ST_RUN);
    assign osc_en     = (st_q != ST_PDOWN);
    assign in_pd      = (st_q == ST_PDOWN);
    assign clr_req    = release_now;
    assign wake_valid = valid_q;
    assign wake_src   = src_q;

    assert_osc_on_wake_R9: assert property (@(posedge clk) disable iff (!rst_all_n)
        (st_q == ST_PDOWN && hit_any) |=> (osc_en && !cpu_clk_en));

    assert_count_step_R9: assert property (@(posedge clk) disable iff (!rst_all_n)
        (st_q == ST_STAB && !cnt_full) |=>
            (st_q == ST_STAB && cnt_q == $past(cnt_q) + 1'b1));

    assert_release_flag_R10: assert property (@(posedge clk) disable iff (!rst_all_n)
        $rose(cpu_clk_en) |-> wake_valid);

    assert_pulse_once_R10: assert property (@(posedge clk) disable iff (!rst_all_n)
        wake_valid |=> !wake_valid);

    assert_reset_hold_R8: assert property (@(posedge clk) disable iff (!rst_all_n)
        (st_q == ST_RHOLD && rst_pin) |=> !cpu_clk_en);
endmodule

// File: rtl/pd_wake_seq.sv
// Top of the power-down wakeup sequencer: register, detector and state machine.
// Assumes all inputs are synchronous to clk; the register is writable only
// while the CPU clock runs.
module pd_wake_seq
    import pdw_pkg::*;
#(
    parameter int CNT_W = 10,
    parameter int KBD_W = 8
) (
    input  logic               clk,
    input  logic               por_n,
    input  logic               rst_n,
    input  logic               reg_we,
    input  logic [7:0]         reg_wdata,
    output logic [7:0]         reg_rdata,
    input  logic [NUM_EXT-1:0] ext_int_pin,
    input  logic [NUM_EXT-1:0] ext_int_en,
    input  logic [NUM_EXT-1:0] ext_int_hi,
    input  logic [NUM_EXT-1:0] ext_int_edge,
    input  logic [KBD_W-1:0]   kbd_pin,
    input  logic [KBD_W-1:0]   kbd_mask,
    input  logic [KBD_W-1:0]   kbd_pattern,
    input  logic               kbd_ie,
    input  logic               ext_rst_pin,
    output logic               osc_en,
    output logic               cpu_clk_en,
    output logic               in_powerdown,
    output logic               wake_valid,
    output logic [SRC_W-1:0]   wake_src
);
    logic             rst_all_n;
    logic             pd_req, idle_req, clr_req;
    logic             hit_any;
    logic [SRC_W-1:0] hit_src;
    logic             wr_ok;

    assign rst_all_n = por_n & rst_n;
    assign wr_ok     = reg_we & cpu_clk_en;

    pdw_ctrl_reg u_ctrl (
        .clk      (clk),
        .por_n    (por_n),
        .rst_n    (rst_n),
        .wr_en    (wr_ok),
        .wr_data  (reg_wdata),
        .clr_req  (clr_req),
        .rd_data  (reg_rdata),
        .pd_req   (pd_req),
        .idle_req (idle_req)
    );

    pdw_wake_detect #(.KBD_W(KBD_W)) u_detect (
        .clk         (clk),
        .rst_all_n   (rst_all_n),
        .force_level (in_powerdown),
        .ext_pin     (ext_int_pin),
        .ext_en      (ext_int_en),
        .ext_hi      (ext_int_hi),
        .ext_edge    (ext_int_edge),
        .kbd_pin     (kbd_pin),
        .kbd_mask    (kbd_mask),
        .kbd_pattern (kbd_pattern),
        .kbd_ie      (kbd_ie),
        .rst_pin     (ext_rst_pin),
        .hit_any     (hit_any),
        .hit_src     (hit_src)
    );

    pdw_seq #(.CNT_W(CNT_W)) u_seq (
        .clk        (clk),
        .rst_all_n  (rst_all_n),
        .pd_req     (pd_req),
        .idle_req   (idle_req),
        .hit_any    (hit_any),
        .hit_src    (hit_src),
        .rst_pin    (ext_rst_pin),
        .osc_en     (osc_en),
        .cpu_clk_en (cpu_clk_en),
        .in_pd      (in_powerdown),
        .clr_req    (clr_req),
        .wake_valid (wake_valid),
        .wake_src   (wake_src)
    );

    assert_pd_entry_R3: assert property (@(posedge clk) disable iff (!rst_all_n)
        (cpu_clk_en && pd_req) |=> (in_powerdown && !osc_en));

    assert_bits_cleared_R11: assert property (@(posedge clk) disable iff (!rst_all_n)
        wake_valid |-> (reg_rdata[1:0] == 2'b00));
endmodule

// File: tb/pd_wake_seq_tb.sv
`timescale 1ns/1ps
module pd_wake_seq_tb;
    localparam int CW       = 6;
    localparam int STAB_LEN = 1 << CW;

    logic       clk = 1'b0;
    logic       por_n, rst_n, reg_we;
    logic [7:0] reg_wdata, reg_rdata;
    logic [2:0] ext_int_pin, ext_int_en, ext_int_hi, ext_int_edge;
    logic [7:0] kbd_pin, kbd_mask, kbd_pattern;
    logic       kbd_ie, ext_rst_pin;
    logic       osc_en, cpu_clk_en, in_powerdown, wake_valid;
    logic [2:0] wake_src;

    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    pd_wake_seq #(.CNT_W(CW), .KBD_W(8)) u_dut (
        .clk(clk), .por_n(por_n), .rst_n(rst_n), .reg_we(reg_we),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .ext_int_pin(ext_int_pin), .ext_int_en(ext_int_en),
        .ext_int_hi(ext_int_hi), .ext_int_edge(ext_int_edge),
        .kbd_pin(kbd_pin), .kbd_mask(kbd_mask), .kbd_pattern(kbd_pattern),
        .kbd_ie(kbd_ie), .ext_rst_pin(ext_rst_pin),
        .osc_en(osc_en), .cpu_clk_en(cpu_clk_en), .in_powerdown(in_powerdown),
        .wake_valid(wake_valid), .wake_src(wake_src)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic report();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    endtask

    // Expected source code from the set of active, enabled sources (R10 priority).
    function automatic logic [2:0] exp_src(input logic [4:0] act);
        if (act[4]) return 3'd4;
        for (int i = 0; i < 3; i++) if (act[i]) return 3'(i);
        return 3'd3;
    endfunction

    task automatic quiet();
        ext_int_en   = 3'b000;
        ext_int_hi   = 3'b000;
        ext_int_edge = 3'b000;
        ext_int_pin  = 3'b111;
        kbd_ie       = 1'b0;
        kbd_mask     = 8'h00;
        kbd_pattern  = 8'h00;
        kbd_pin      = 8'h00;
        ext_rst_pin  = 1'b0;
    endtask

    // Full power-down cycle with random sources; called at a falling edge in run.
    task automatic pd_trial(input logic [7:0] wdata, input logic force_rst, input int hold_in);
        logic [2:0] want;
        logic       kbd_want, rst_want;
        logic [4:0] act;
        int         hold, e;
        ext_int_en   = 3'($urandom);
        ext_int_hi   = 3'($urandom);
        ext_int_edge = 3'($urandom);
        want         = 3'($urandom);
        kbd_ie       = 1'($urandom);
        kbd_want     = 1'($urandom);
        kbd_mask     = 8'($urandom) | 8'h01;
        kbd_pattern  = 8'($urandom);
        rst_want     = force_rst | (($urandom % 4) == 0);
        hold         = force_rst ? hold_in :
                       (($urandom % 2) == 0 ? 5 + int'($urandom % 40) : STAB_LEN + int'($urandom % 20));
        act = {rst_want, kbd_ie & kbd_want, ext_int_en & want};
        if (act == 5'b0) begin
            ext_int_en[0] = 1'b1; want[0] = 1'b1; act[0] = 1'b1;
        end
        for (int i = 0; i < 3; i++)
            ext_int_pin[i] = (want[i] && !ext_int_en[i]) ? ext_int_hi[i] : ~ext_int_hi[i];
        kbd_pin   = (kbd_want && !kbd_ie) ? kbd_pattern : (kbd_pattern ^ kbd_mask);
        reg_we    = 1'b1;
        reg_wdata = wdata;
        @(negedge clk);
        reg_we = 1'b0;
        @(negedge clk);
        chk("R3 in_powerdown", 32'(in_powerdown), 1);
        chk("R3 cpu_clk_en", 32'(cpu_clk_en), 0);
        chk("R3 osc_en", 32'(osc_en), 0);
        chk("R4 bits 1:0", 32'(reg_rdata[1:0]), 2);
        repeat (6) @(negedge clk);
        chk("R6 R7 disabled sources keep power-down", 32'(in_powerdown), 1);
        for (int i = 0; i < 3; i++) if (want[i]) ext_int_pin[i] = ext_int_hi[i];
        if (kbd_want) kbd_pin = kbd_pattern ^ (8'($urandom) & ~kbd_mask);
        if (rst_want) ext_rst_pin = 1'b1;
        @(negedge clk);
        chk("R9 osc_en after wake", 32'(osc_en), 1);
        chk("R9 clock still gated", 32'(cpu_clk_en), 0);
        e = (rst_want && hold >= STAB_LEN) ? hold + 1 : STAB_LEN;
        for (int j = 1; j <= e; j++) begin
            @(negedge clk);
            if (j == e - 1) chk("R9 R8 gated one cycle before release", 32'(cpu_clk_en), 0);
            if (j == e) begin
                chk("R9 R8 clock released", 32'(cpu_clk_en), 1);
                chk("R10 wake_valid", 32'(wake_valid), 1);
                chk("R10 wake_src", 32'(wake_src), 32'(exp_src(act)));
            end
            if (rst_want && j == hold) ext_rst_pin = 1'b0;
        end
        @(negedge clk);
        chk("R10 pulse ends", 32'(wake_valid), 0);
        chk("R11 bits cleared", 32'(reg_rdata[1:0]), 0);
        repeat (4) @(negedge clk);
        chk("R11 no second sleep", 32'(cpu_clk_en), 1);
        quiet();
        @(negedge clk);
    endtask

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        report();
        $finish;
    end

    initial begin
        int seed_set;
        seed_set = int'($urandom(32'd4242));
        quiet();
        por_n = 1'b0; rst_n = 1'b0; reg_we = 1'b0; reg_wdata = 8'h00;
        repeat (3) @(negedge clk);
        por_n = 1'b1; rst_n = 1'b1;
        @(negedge clk);
        chk("R1 reg after power-on", 32'(reg_rdata), 32'h10);
        chk("R1 cpu_clk_en", 32'(cpu_clk_en), 1);
        chk("R1 osc_en", 32'(osc_en), 1);
        chk("R1 in_powerdown", 32'(in_powerdown), 0);
        chk("R1 wake_valid", 32'(wake_valid), 0);

        // R2: system reset keeps only the power-on flag.
        reg_we = 1'b1; reg_wdata = 8'h3C;
        @(negedge clk); reg_we = 1'b0;
        chk("R2 write readback", 32'(reg_rdata), 32'h3C);
        rst_n = 1'b0; @(negedge clk); rst_n = 1'b1;
        chk("R2 flag kept set", 32'(reg_rdata), 32'h10);
        reg_we = 1'b1; reg_wdata = 8'h0C;
        @(negedge clk); reg_we = 1'b0;
        rst_n = 1'b0; @(negedge clk); rst_n = 1'b1;
        chk("R2 flag kept clear", 32'(reg_rdata), 32'h00);
        por_n = 1'b0; @(negedge clk); por_n = 1'b1;
        chk("R1 power-on sets flag", 32'(reg_rdata), 32'h10);

        // R5: idle, level-configured interrupt 0 wakes on the next edge.
        quiet(); ext_int_en = 3'b001;
        reg_we = 1'b1; reg_wdata = 8'h01;
        @(negedge clk); reg_we = 1'b0;
        @(negedge clk);
        chk("R5 idle gates clock", 32'(cpu_clk_en), 0);
        chk("R5 idle keeps osc", 32'(osc_en), 1);
        ext_int_pin[0] = 1'b0;
        @(negedge clk);
        chk("R5 idle wake clock", 32'(cpu_clk_en), 1);
        chk("R5 idle wake pulse", 32'(wake_valid), 1);
        chk("R5 idle wake src", 32'(wake_src), 0);
        chk("R11 idle bit cleared", 32'(reg_rdata[0]), 0);
        quiet(); @(negedge clk);

        // R5: edge-configured interrupt 1 needs a transition in idle.
        ext_int_en = 3'b010; ext_int_edge = 3'b010; ext_int_hi = 3'b010; ext_int_pin = 3'b011;
        reg_we = 1'b1; reg_wdata = 8'h01;
        @(negedge clk); reg_we = 1'b0;
        repeat (8) @(negedge clk);
        chk("R5 steady level ignored in idle", 32'(cpu_clk_en), 0);
        ext_int_pin[1] = 1'b0; @(negedge clk); @(negedge clk);
        chk("R5 still idle", 32'(cpu_clk_en), 0);
        ext_int_pin[1] = 1'b1; @(negedge clk);
        chk("R5 edge wakes idle", 32'(cpu_clk_en), 1);
        chk("R5 edge wake src", 32'(wake_src), 1);
        quiet(); @(negedge clk);

        // R10: interrupt 2 beats keypad in the same cycle.
        ext_int_en = 3'b100; ext_int_pin = 3'b111;
        kbd_ie = 1'b1; kbd_mask = 8'hF0; kbd_pattern = 8'hA0; kbd_pin = 8'h00;
        reg_we = 1'b1; reg_wdata = 8'h01;
        @(negedge clk); reg_we = 1'b0;
        @(negedge clk);
        ext_int_pin[2] = 1'b0; kbd_pin = 8'hA5;
        @(negedge clk);
        chk("R10 priority int2 over keypad", 32'(wake_src), 2);
        quiet(); @(negedge clk);

        // R6: edge-configured interrupt already active before power-down wakes by level.
        ext_int_en = 3'b100; ext_int_edge = 3'b100; ext_int_hi = 3'b100; ext_int_pin = 3'b111;
        reg_we = 1'b1; reg_wdata = 8'h02;
        @(negedge clk); reg_we = 1'b0;
        @(negedge clk);
        chk("R6 entered power-down", 32'(in_powerdown), 1);
        @(negedge clk);
        chk("R6 forced level wakes", 32'(osc_en), 1);
        repeat (STAB_LEN) @(negedge clk);
        chk("R6 release after hold", 32'(cpu_clk_en), 1);
        chk("R6 wake src", 32'(wake_src), 2);
        quiet(); @(negedge clk);

        // R8: reset pin wake held past the count, and dropped before it.
        pd_trial(8'h02, 1'b1, STAB_LEN + 7);
        pd_trial(8'h02, 1'b1, 3);
        // R4: both request bits written together.
        pd_trial(8'h03, 1'b0, 0);
        for (int t = 0; t < 16; t++) pd_trial({4'($urandom), 2'b00, 2'b10}, 1'b0, 0);

        report();
        $finish;
    end
endmodule